// File: doc/BRIEF.md
# Byte-wide SPI master with a memory-mapped register interface

This block is an SPI master that hangs off a simple single-cycle register bus. Software sets up the serial clock rate and the clock mode through a control register. Writing a byte to the data register launches one full-duplex exchange of eight bits. The byte shifted in from the slave is read back from the same data register. Chip select is not part of the block; software drives it from a general-purpose output around each exchange.

A status register shows the two flags that software polls. One flag is high while bits are on the wire. The other is high while a completed received byte is waiting to be read. The control register can be rewritten at any time. The enable bit acts at once and aborts an exchange in progress. Changes to the clock rate and clock mode are held back until the next byte starts.

Top module: `spim_master`

## Requirements
- R1: Register map with a 3-bit byte address: the data register is at 0, the control register at 2, and the status register at 4. The control register has enable at bit 0, clock phase at bit 7, clock polarity (idle level) at bit 8, and the divider at bits 15:9. The status register has busy at bit 0 and received-byte-ready at bit 1. The control register reads back the last value written to it.
- R2: While the block is enabled and idle, a write to the data register starts one exchange of 8 bits, sent and received most significant bit first. The received byte is then returned by a read of the data register.
- R3: Each half-period of the serial clock lasts divider+1 bus clocks, so busy stays high for exactly 16*(divider+1) cycles. The largest divider, 127, gives 2048 cycles.
- R4: The serial clock rests at the polarity bit's level and toggles exactly 16 times per exchange. With phase 0 the slave's bit is sampled on the first edge of each bit, and with phase 1 on the second edge. The output bit stays stable across its sampling edge in all four modes.
- R5: Received-byte-ready rises in the same cycle that busy falls at the end of an exchange. A read of the data register clears it.
- R6: A write to the data register while busy is high has no effect: the byte on the wire, the received byte and the exchange length are unchanged, and no second exchange follows.
- R7: A write to the data register while the enable bit is clear starts nothing: busy stays low and the serial clock does not move.
- R8: Clearing the enable bit aborts an exchange. One cycle after the new control value is held, busy is low and the serial clock sits at the idle level, while received-byte-ready keeps its value.
- R9: Divider and mode written during an exchange do not affect that exchange. They apply from the next byte onward.
- R10: After reset, the control register, the status flags and the data register read as zero, and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (clears received-byte-ready at address 0) |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 16 | Write data (low byte used for the data register) |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench builds the block with its default parameters: a 7-bit divider field and 8-bit exchanges, which gives the 16-bit control register. At these values the full divider range is cheap to reach. Divider 0 is the fastest case, with a one-cycle half-period that stresses the edge bookkeeping. Divider 127, at 2048 cycles per byte, shows that the field saturates and does not wrap. The bench models a slave that follows the current mode, so all four polarity and phase combinations are checked in both directions, along with writes that land in the middle of an exchange.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int ADDR_W    = 3;
    localparam int EN_BIT    = 0;
    localparam int CPHA_BIT  = 7;
    localparam int CPOL_BIT  = 8;
    localparam int DIV_LSB   = 9;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } spim_mode_t;

endpackage

// File: rtl/spim_halfper.sv
module spim_halfper #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int XFER_BITS = 8,
    parameter int DIV_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abort,
    input  logic                 tick,
    input  spim_mode_t           mode_in,
    input  logic [DIV_W-1:0]     div_in,
    input  logic [XFER_BITS-1:0] tx_in,
    input  logic                 miso,
    output logic                 busy,
    output logic                 done,
    output logic [DIV_W-1:0]     div_act,
    output logic                 sclk,
    output logic                 mosi,
    output logic [XFER_BITS-1:0] rx_data
);

    localparam int EDGES = 2 * XFER_BITS;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    typedef struct packed {
        logic                 busy;
        logic [EW-1:0]        edge_n;
        logic                 sclk;
        spim_mode_t           mode;
        logic [DIV_W-1:0]     div;
        logic [XFER_BITS-1:0] tx;
        logic [XFER_BITS-1:0] rx;
        logic [XFER_BITS-1:0] rxbuf;
    } eng_st_t;

    eng_st_t s_d, s_q;
    logic    lead, smp;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        lead = ~s_q.edge_n[0];
        smp  = lead ^ s_q.mode.cpha;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.sclk = mode_in.cpol;
        end else if (!s_q.busy) begin
            s_d.sclk = mode_in.cpol;
            s_d.mode = mode_in;
            s_d.div  = div_in;
            if (start) begin
                s_d.busy   = 1'b1;
                s_d.edge_n = '0;
                s_d.tx     = tx_in;
            end
        end else if (tick) begin
            s_d.sclk = ~s_q.sclk;
            if (smp)
                s_d.rx = {s_q.rx[XFER_BITS-2:0], miso};
            else if (!(s_q.mode.cpha && s_q.edge_n == '0))
                s_d.tx = {s_q.tx[XFER_BITS-2:0], 1'b0};
            if (s_q.edge_n == LAST_EDGE) begin
                s_d.busy  = 1'b0;
                s_d.rxbuf = s_d.rx;
                done      = 1'b1;
            end
            s_d.edge_n = s_q.edge_n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign div_act = s_q.div;
    assign sclk    = s_q.sclk;
    assign mosi    = s_q.tx[XFER_BITS-1];
    assign rx_data = s_q.rxbuf;

endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter  int DIV_W     = 7,
    parameter  int XFER_BITS = 8,
    localparam int BUS_W     = DIV_LSB + DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    typedef struct packed {
        logic [BUS_W-1:0] ctrl;
        logic             rxfull;
    } top_st_t;

    top_st_t              st_d, st_q;
    logic                 ctrl_en, ctrl_cpol, busy, done, tick, start, rxfull;
    spim_mode_t           mode_cur;
    logic [DIV_W-1:0]     div_cur, div_act;
    logic [XFER_BITS-1:0] rx_data;

    assign ctrl_en   = st_q.ctrl[EN_BIT];
    assign ctrl_cpol = st_q.ctrl[CPOL_BIT];
    assign mode_cur  = '{cpol: st_q.ctrl[CPOL_BIT], cpha: st_q.ctrl[CPHA_BIT]};
    assign div_cur   = st_q.ctrl[DIV_LSB +: DIV_W];
    assign rxfull    = st_q.rxfull;

    always_comb begin
        st_d  = st_q;
        start = bus_wr && (bus_addr == A_DATA) && ctrl_en && !busy;
        if (bus_wr && bus_addr == A_CTRL)
            st_d.ctrl = bus_wdata;
        if (done)
            st_d.rxfull = 1'b1;
        else if (bus_rd && bus_addr == A_DATA)
            st_d.rxfull = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = BUS_W'(rx_data);
            A_CTRL:  bus_rdata = st_q.ctrl;
            A_STAT:  bus_rdata = BUS_W'({rxfull, busy});
            default: bus_rdata = '0;
        endcase
    end

    spim_halfper #(.DIV_W(DIV_W)) u_halfper (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (div_act),
        .tick (tick)
    );

    spim_engine #(.XFER_BITS(XFER_BITS), .DIV_W(DIV_W)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .abort  (!ctrl_en),
        .tick   (tick),
        .mode_in(mode_cur),
        .div_in (div_cur),
        .tx_in  (bus_wdata[XFER_BITS-1:0]),
        .miso   (miso),
        .busy   (busy),
        .done   (done),
        .div_act(div_act),
        .sclk   (sclk),
        .mosi   (mosi),
        .rx_data(rx_data)
    );

endmodule

// File: rtl/spim_chk.sv
module spim_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] bus_addr,
    input logic       en,
    input logic       cpol,
    input logic       busy,
    input logic       done,
    input logic       rxfull,
    input logic       sclk
);

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    p_start_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr == 3'd0 && en));

    p_rxfull_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0 && !done) |=> !rxfull);

    p_end_sets_rxfull_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(en)) |-> rxfull);

    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(cpol)) |-> (sclk == cpol));

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy);

endmodule

bind spim_master spim_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .en      (ctrl_en),
    .cpol    (ctrl_cpol),
    .busy    (busy),
    .done    (done),
    .rxfull  (rxfull),
    .sclk    (sclk)
);

// File: tb/spim_master_tb.sv
module spim_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd4;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spim_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // slave model
    logic       mon_on = 1'b0;
    logic       tb_cpol = 1'b0, tb_cpha = 1'b0;
    logic [7:0] slv_byte = '0, m_cap = '0;
    int         s_idx = 0, tog = 0;

    always @(sclk) begin
        if (mon_on) begin
            tog = tog + 1;
            if (((sclk != tb_cpol) ^ tb_cpha)) begin
                m_cap = {m_cap[6:0], mosi};
                s_idx = s_idx + 1;
                miso  = (s_idx < 8) ? slv_byte[7 - s_idx] : 1'b0;
            end
        end
    end

    // mode, div, tx, slave byte
    localparam logic [24:0] VEC [6] = '{
        {2'b00, 7'd0, 8'hA5, 8'h3C},
        {2'b01, 7'd1, 8'h5A, 8'hC3},
        {2'b10, 7'd2, 8'h81, 8'h7E},
        {2'b11, 7'd0, 8'hFF, 8'h00},
        {2'b00, 7'd5, 8'h00, 8'hFF},
        {2'b11, 7'd3, 8'h96, 8'h69}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd4;
        #1;
    endtask

    task automatic bread(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 3'd4;
        #1;
    endtask

    function automatic logic [15:0] ctrl_word(input logic [1:0] m, input logic [6:0] dv, input logic en);
        return {dv, m[1], m[0], 6'b0, en};
    endfunction

    task automatic arm_slave(input logic [1:0] m, input logic [7:0] s);
        tb_cpol = m[1]; tb_cpha = m[0];
        slv_byte = s; s_idx = 0; m_cap = '0; tog = 0;
        miso = s[7]; mon_on = 1'b1;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (bus_rdata[0]) begin
            cnt++;
            @(negedge clk); #1;
        end
    endtask

    task automatic run_xfer(input logic [1:0] m, input logic [6:0] dv, input logic [7:0] tx,
                            input logic [7:0] s, input bit wr_ctrl, input bit mid, input logic [15:0] mid_val);
        int cnt;
        logic [15:0] rd;
        if (wr_ctrl) begin
            bwrite(3'd2, ctrl_word(m, dv, 1'b1));
            repeat (2) @(negedge clk);
        end
        arm_slave(m, s);
        bwrite(3'd0, {8'h00, tx});
        if (mid) begin
            bwrite(3'd2, mid_val);
            wait_idle(cnt);
            cnt = cnt + 2;
        end else begin
            wait_idle(cnt);
        end
        mon_on = 1'b0;
        chk("R3 busy length", cnt, 16 * (dv + 1));
        chk("R4 sclk toggles", tog, 16);
        chk("R4 idle level", sclk, m[1]);
        chk("R4 mosi bits seen by slave", m_cap, tx);
        chk("R5 rxfull at end", bus_rdata[1], 1'b1);
        bread(3'd0, rd);
        chk("R2 received byte", rd, {8'h00, s});
        chk("R5 rxfull cleared by read", bus_rdata[1:0], 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R10 reset state
        bread(3'd2, rd); chk("R10 ctrl after reset", rd, 16'h0000);
        bread(3'd4, rd); chk("R10 status after reset", rd, 16'h0000);
        bread(3'd0, rd); chk("R10 data after reset", rd, 16'h0000);
        chk("R10 sclk after reset", sclk, 1'b0);

        // vector table: R2 R3 R4 R5 in all modes
        for (int i = 0; i < 6; i++) begin
            run_xfer(VEC[i][24:23], VEC[i][22:16], VEC[i][15:8], VEC[i][7:0], 1'b1, 1'b0, 16'h0);
        end

        // R7 data write while disabled
        bwrite(3'd2, ctrl_word(2'b00, 7'd0, 1'b0));
        repeat (2) @(negedge clk);
        arm_slave(2'b00, 8'h00);
        bwrite(3'd0, 16'h0055);
        repeat (20) @(negedge clk); #1;
        mon_on = 1'b0;
        chk("R7 no busy when disabled", bus_rdata[1:0], 2'b00);
        chk("R7 sclk still", tog, 0);

        // R1 control readback, R3 slowest divider
        bwrite(3'd2, 16'hFE81);
        bread(3'd2, rd); chk("R1 ctrl readback", rd, 16'hFE81);
        run_xfer(2'b01, 7'd127, 8'hC6, 8'h3A, 1'b0, 1'b0, 16'h0);

        // R6 write while busy ignored
        bwrite(3'd2, ctrl_word(2'b10, 7'd2, 1'b1));
        repeat (2) @(negedge clk);
        arm_slave(2'b10, 8'hB4);
        bwrite(3'd0, 16'h00E1);
        repeat (5) @(negedge clk);
        bwrite(3'd0, 16'h0018);
        wait_idle(cnt);
        mon_on = 1'b0;
        chk("R6 first byte kept on wire", m_cap, 8'hE1);
        chk("R6 toggles unchanged", tog, 16);
        repeat (10) @(negedge clk); #1;
        chk("R6 no second exchange", bus_rdata[0], 1'b0);
        bread(3'd0, rd); chk("R6 received byte intact", rd, 16'h00B4);

        // R9 control written mid-transfer applies to next byte
        bwrite(3'd2, ctrl_word(2'b00, 7'd1, 1'b1));
        repeat (2) @(negedge clk);
        run_xfer(2'b00, 7'd1, 8'h3E, 8'hD2, 1'b0, 1'b1, ctrl_word(2'b11, 7'd0, 1'b1));
        repeat (2) @(negedge clk);
        run_xfer(2'b11, 7'd0, 8'h47, 8'h9B, 1'b0, 1'b0, 16'h0);

        // R8 abort keeps rxfull, returns sclk to idle
        bwrite(3'd2, ctrl_word(2'b00, 7'd3, 1'b1));
        repeat (2) @(negedge clk);
        arm_slave(2'b00, 8'h11);
        bwrite(3'd0, 16'h0022);
        wait_idle(cnt);
        mon_on = 1'b0;
        chk("R5 rxfull before abort", bus_rdata[1], 1'b1);
        bwrite(3'd0, 16'h0033);
        repeat (10) @(negedge clk); #1;
        chk("R8 busy before abort", bus_rdata[0], 1'b1);
        bwrite(3'd2, ctrl_word(2'b10, 7'd3, 1'b0));
        @(negedge clk); #1;
        chk("R8 busy cleared by abort", bus_rdata[0], 1'b0);
        chk("R8 rxfull kept", bus_rdata[1], 1'b1);
        chk("R8 sclk idle after abort", sclk, 1'b1);
        bread(3'd0, rd); chk("R8 data from last complete byte", rd, 16'h0011);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule